// File: doc/BRIEF.md
# LIN-Capable Asynchronous Serial Transceiver

A full-duplex asynchronous serial transceiver that can also act as a LIN bus node. Transmit and receive run independently and at the same time. Each direction has one holding register in front of one shift register, so software can queue the next byte while the current one is on the wire, and can leave a received byte unread while the next one arrives. A programmable divider derives a 16x oversampling tick from the system clock. Every bit, in either direction, is 16 ticks long.

In master role, a break request drives the line low for a programmable 13 to 16 bit times. The line is then held high for a delimiter of 1 to 4 bit times. Data already waiting in the transmit holding register leaves only after the delimiter, with its start bit directly following it. In slave role, the receiver watches for the line staying low for 11 bit times and raises a sticky break flag. The receiver also reports parity, framing and overrun errors.

Software reaches the block through a four-entry register port with a write strobe, a read strobe and a combinational read path. Address 0 is the data register, 1 is control, 2 is the divider and 3 is status.

Top module: `lin_xcvr`

## Requirements
- R1: After reset, tx_o is high and control and divider read 0x00. Status (address 3) reads 0x06. The status bits are: bit0 = receive byte waiting, bit1 = transmit holding empty, bit2 = transmitter fully idle, bit3 = parity error, bit4 = framing error, bit5 = overrun, bit6 = break detected, bit7 = break request or break/delimiter in progress.
- R2: One bit time is 16*(div+1) clock cycles, where div is the value written at address 2.
- R3: A data frame is sent as one low start bit, then 8 data bits LSB first, then a parity bit if control bit0 is set, then one high stop bit. The parity bit is the XOR of the data when control bit1 is 0 (even parity), and the inverted XOR when control bit1 is 1 (odd parity).
- R4: A byte written at address 0 while the transmitter is busy is held in the holding register. Its start bit begins in the same cycle that the preceding stop bit or delimiter ends.
- R5: Writing control with bit7 = 1 and bit2 = 1 (master) produces a low break field of 13 + control[4:3] bit times.
- R6: The break is followed by a high delimiter of 1 + control[6:5] bit times.
- R7: A break request written with control bit2 = 0 (slave) is ignored: tx_o stays high and status bit7 stays 0.
- R8: With tx_o looped back to rx_i, each of the 256 byte values is received intact, under both parity senses, with no error flag.
- R9: If parity is enabled and the received parity bit does not match the configured sense, status bit3 is set and the byte is still delivered.
- R10: A stop bit sampled low sets status bit4, and the byte is still delivered.
- R11: If a byte completes while status bit0 is still set, status bit5 is set and the earlier byte is kept.
- R12: In slave role, rx_i staying low for at least 11 bit times sets status bit6. A low of 10 bit times does not set it, and master role never sets it.
- R13: Writing 1s at address 3 clears the matching bits among status bits 3 to 6. Reading address 0 with rd_en_i clears status bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe (pops the receive byte at address 0) |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
Line timing is checked to the exact cycle. The break begins on the tick after the request write. It lasts exactly (13+sel)*16 cycles at div 0, and the delimiter then lasts exactly (1+sel)*16 cycles before the queued start bit falls. At div 2, a zero byte holds the line low for exactly 432 cycles. The bench samples the line on falling edges, so every count is free of edge races. Transmitted bits are sampled 8 cycles into each 16-cycle bit. Received results become visible two synchroniser cycles plus half a bit after the stop bit begins. The bench therefore reads status only after a whole frame plus idle time, or by polling the receive-full bit with a bound.

// File: rtl/lin_xcvr_pkg.sv
package lin_xcvr_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_BRK, TX_DLM, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  localparam int unsigned BRK_BASE  = 13;
  localparam int unsigned DLM_BASE  = 1;
  localparam int unsigned DATA_BITS = 8;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/lin_baud_gen.sv
module lin_baud_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the period sane if the divider is lowered mid-count
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lin_tx.sv
module lin_tx
  import lin_xcvr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       brk_req_i,
  input  logic [1:0] brk_sel_i,
  input  logic [1:0] dlm_sel_i,
  output logic       tx_o,
  output logic       thr_full_o,
  output logic       idle_o,
  output logic       brk_busy_o,
  output logic       start_o
);
  localparam int unsigned OS_W  = $clog2(OSR);
  localparam int unsigned BIT_W = 5;

  tx_state_e        state_q;
  logic [OS_W-1:0]  os_q;
  logic [BIT_W-1:0] bit_q;
  logic [7:0]       shf_q, thr_q;
  logic             par_q, thr_full_q, pend_q;
  logic             bit_end;
  logic [BIT_W-1:0] brk_len, dlm_len;

  assign bit_end = tick_i && (os_q == OS_W'(OSR-1));
  assign brk_len = BIT_W'(BRK_BASE) + BIT_W'(brk_sel_i);
  assign dlm_len = BIT_W'(DLM_BASE) + BIT_W'(dlm_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      os_q       <= '0;
      bit_q      <= '0;
      shf_q      <= '0;
      thr_q      <= '0;
      par_q      <= 1'b0;
      thr_full_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      if (load_i && !thr_full_q) begin
        thr_q      <= load_data_i;
        thr_full_q <= 1'b1;
      end
      if (tick_i && state_q != TX_IDLE)
        os_q <= bit_end ? '0 : os_q + 1'b1;

      unique case (state_q)
        TX_IDLE: if (tick_i) begin
          os_q <= '0;
          if (pend_q) begin
            state_q <= TX_BRK;
            bit_q   <= '0;
            pend_q  <= 1'b0;
          end else if (thr_full_q) begin
            state_q    <= TX_START;
            shf_q      <= thr_q;
            par_q      <= (^thr_q) ^ par_odd_i;
            thr_full_q <= 1'b0;
          end
        end
        TX_BRK: if (bit_end) begin
          if (bit_q == brk_len - 1'b1) begin
            state_q <= TX_DLM;
            bit_q   <= '0;
          end else bit_q <= bit_q + 1'b1;
        end
        TX_DLM: if (bit_end) begin
          if (bit_q == dlm_len - 1'b1) begin
            // queued data follows the delimiter with no gap
            if (thr_full_q) begin
              state_q    <= TX_START;
              shf_q      <= thr_q;
              par_q      <= (^thr_q) ^ par_odd_i;
              thr_full_q <= 1'b0;
            end else state_q <= TX_IDLE;
          end else bit_q <= bit_q + 1'b1;
        end
        TX_START: if (bit_end) begin
          state_q <= TX_DATA;
          bit_q   <= '0;
        end
        TX_DATA: if (bit_end) begin
          shf_q <= shf_q >> 1;
          if (bit_q == BIT_W'(DATA_BITS-1)) state_q <= par_en_i ? TX_PAR : TX_STOP;
          else bit_q <= bit_q + 1'b1;
        end
        TX_PAR: if (bit_end) state_q <= TX_STOP;
        TX_STOP: if (bit_end) begin
          if (pend_q) begin
            state_q <= TX_BRK;
            bit_q   <= '0;
            pend_q  <= 1'b0;
          end else if (thr_full_q) begin
            state_q    <= TX_START;
            shf_q      <= thr_q;
            par_q      <= (^thr_q) ^ par_odd_i;
            thr_full_q <= 1'b0;
          end else state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase

      if (brk_req_i) pend_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      TX_BRK, TX_START: tx_o = 1'b0;
      TX_DATA:          tx_o = shf_q[0];
      TX_PAR:           tx_o = par_q;
      default:          tx_o = 1'b1;
    endcase
  end

  assign thr_full_o = thr_full_q;
  assign idle_o     = (state_q == TX_IDLE) && !thr_full_q && !pend_q;
  assign brk_busy_o = pend_q || state_q == TX_BRK || state_q == TX_DLM;
  assign start_o    = (state_q == TX_START);
endmodule

// File: rtl/lin_rx.sv
module lin_rx
  import lin_xcvr_pkg::*;
#(
  parameter int unsigned OSR          = 16,
  parameter int unsigned BRK_DET_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       master_i,
  input  logic       rd_i,
  input  logic [3:0] clr_i,
  output logic [7:0] data_o,
  output logic       full_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       ovr_err_o,
  output logic       brk_det_o
);
  localparam int unsigned OS_W   = $clog2(OSR);
  localparam int unsigned MID    = OSR/2 - 1;
  localparam int unsigned DET_TH = BRK_DET_BITS * OSR;
  localparam int unsigned DET_W  = $clog2(DET_TH + 1);

  rx_state_e       state_q;
  logic [OS_W-1:0] os_q;
  logic [2:0]      bit_q;
  logic [7:0]      shf_q, hold_q;
  logic            s1_q, s2_q, par_bit_q;
  logic            full_q, perr_q, ferr_q, oerr_q, bdet_q;
  logic [DET_W-1:0] low_q;
  logic            mid, bit_end;

  assign mid     = tick_i && (os_q == OS_W'(MID));
  assign bit_end = tick_i && (os_q == OS_W'(OSR-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
      state_q <= RX_IDLE; os_q <= '0; bit_q <= '0;
      shf_q <= '0; hold_q <= '0; par_bit_q <= 1'b0;
      full_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
      oerr_q <= 1'b0; bdet_q <= 1'b0; low_q <= '0;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      if (rd_i)     full_q <= 1'b0;
      if (clr_i[0]) perr_q <= 1'b0;
      if (clr_i[1]) ferr_q <= 1'b0;
      if (clr_i[2]) oerr_q <= 1'b0;
      if (clr_i[3]) bdet_q <= 1'b0;

      // break detector counts ticks of continuous low
      if (s2_q) low_q <= '0;
      else if (tick_i && low_q < DET_W'(DET_TH)) begin
        low_q <= low_q + 1'b1;
        if (low_q == DET_W'(DET_TH-1) && !master_i) bdet_q <= 1'b1;
      end

      if (tick_i && state_q != RX_IDLE) os_q <= bit_end ? '0 : os_q + 1'b1;

      unique case (state_q)
        RX_IDLE: if (tick_i && !s2_q) begin
          state_q <= RX_START;
          os_q    <= '0;
        end
        RX_START: begin
          if (mid && s2_q) begin
            state_q <= RX_IDLE;
            os_q    <= '0;
          end else if (bit_end) begin
            state_q <= RX_DATA;
            bit_q   <= '0;
          end
        end
        RX_DATA: begin
          if (mid) shf_q <= {s2_q, shf_q[7:1]};
          if (bit_end) begin
            if (bit_q == 3'(DATA_BITS-1)) state_q <= par_en_i ? RX_PAR : RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (mid) par_bit_q <= s2_q;
          if (bit_end) state_q <= RX_STOP;
        end
        RX_STOP: if (mid) begin
          state_q <= RX_IDLE;
          os_q    <= '0;
          if (!s2_q) ferr_q <= 1'b1;
          if (par_en_i && (par_bit_q != ((^shf_q) ^ par_odd_i))) perr_q <= 1'b1;
          if (full_q && !rd_i) oerr_q <= 1'b1;
          else begin
            hold_q <= shf_q;
            full_q <= 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o    = hold_q;
  assign full_o    = full_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;
  assign ovr_err_o = oerr_q;
  assign brk_det_o = bdet_q;
endmodule

// File: rtl/lin_xcvr.sv
module lin_xcvr
  import lin_xcvr_pkg::*;
#(
  parameter int unsigned DIV_W        = 8,
  parameter int unsigned OSR          = 16,
  parameter int unsigned BRK_DET_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  input  logic       rx_i,
  output logic       tx_o
);
  // ctrl: [0] parity en, [1] odd, [2] master, [4:3] break sel, [6:5] delimiter sel
  logic [6:0]       ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             tick, brk_req, load, pop;
  logic [3:0]       clr;
  logic             thr_full, tx_idle, brk_busy, tx_start;
  logic [7:0]       rx_data;
  logic             rx_full, par_err, frm_err, ovr_err, brk_det;

  assign brk_req = wr_en_i && wr_addr_i == A_CTRL && wr_data_i[7] && wr_data_i[2];
  assign load    = wr_en_i && wr_addr_i == A_DATA;
  assign pop     = rd_en_i && rd_addr_i == A_DATA;
  assign clr     = (wr_en_i && wr_addr_i == A_STAT) ? wr_data_i[6:3] : 4'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) ctrl_q <= wr_data_i[6:0];
      if (wr_addr_i == A_DIV)  div_q  <= wr_data_i[DIV_W-1:0];
    end
  end

  lin_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk_i, .rst_ni, .div_i(div_q), .tick_o(tick)
  );

  lin_tx #(.OSR(OSR)) i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .load_data_i(wr_data_i),
    .par_en_i(ctrl_q[0]), .par_odd_i(ctrl_q[1]), .brk_req_i(brk_req),
    .brk_sel_i(ctrl_q[4:3]), .dlm_sel_i(ctrl_q[6:5]), .tx_o,
    .thr_full_o(thr_full), .idle_o(tx_idle), .brk_busy_o(brk_busy), .start_o(tx_start)
  );

  lin_rx #(.OSR(OSR), .BRK_DET_BITS(BRK_DET_BITS)) i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i, .par_en_i(ctrl_q[0]), .par_odd_i(ctrl_q[1]),
    .master_i(ctrl_q[2]), .rd_i(pop), .clr_i(clr), .data_o(rx_data), .full_o(rx_full),
    .par_err_o(par_err), .frm_err_o(frm_err), .ovr_err_o(ovr_err), .brk_det_o(brk_det)
  );

  always_comb begin
    unique case (rd_addr_i)
      A_DATA:  rd_data_o = rx_data;
      A_CTRL:  rd_data_o = {1'b0, ctrl_q};
      A_DIV:   rd_data_o = 8'(div_q);
      default: rd_data_o = {brk_busy, brk_det, ovr_err, frm_err, par_err,
                            tx_idle, !thr_full, rx_full};
    endcase
  end
endmodule

// File: rtl/lin_xcvr_chk.sv
module lin_xcvr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic tx_i,
  input logic thr_full_i,
  input logic tx_start_i,
  input logic rx_full_i,
  input logic ovr_err_i,
  input logic brk_det_i,
  input logic master_i,
  input logic frm_err_i,
  input logic clr_frm_i
);
  // R2
  tx_tick_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tx_i));
  // R4
  hold_to_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(thr_full_i) |-> tx_start_i);
  // R11
  ovr_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_i) |-> $past(rx_full_i));
  // R12
  brk_slave_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_det_i) |-> !$past(master_i));
  // R10
  frm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_i && !clr_frm_i |=> frm_err_i);
endmodule

bind lin_xcvr lin_xcvr_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .tx_i(tx_o),
  .thr_full_i(thr_full), .tx_start_i(tx_start), .rx_full_i(rx_full),
  .ovr_err_i(ovr_err), .brk_det_i(brk_det), .master_i(ctrl_q[2]),
  .frm_err_i(frm_err), .clr_frm_i(clr[1])
);

// File: tb/test_lin_xcvr.sv
module test_lin_xcvr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd3;
  logic [7:0] wr_data = '0, rd_data;
  logic rx_drv = 1'b1, loop = 1'b0, tx;
  logic rx;
  int checks = 0, errors = 0, cyc = 0;

  assign rx = loop ? tx : rx_drv;
  always #5 clk = ~clk;

  lin_xcvr i_lin_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rx_i(rx), .tx_o(tx)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit pop, output logic [7:0] d);
    @(negedge clk); rd_addr = a; rd_en = pop; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0; rd_addr = 2'd3;
  endtask

  task automatic wait_level(input logic lvl);
    int n = 0;
    while (tx !== lvl && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (tx === lvl && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_stat(input int idx, input logic val);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd3, 1'b0, s);
      if (s[idx] === val) break;
    end
  endtask

  task automatic send_rx(input logic [7:0] v, input bit pen, input bit pb, input bit sb);
    logic [10:0] bits;
    int nb;
    bits = pen ? {sb, pb, v, 1'b0} : {1'b0, sb, v, 1'b0};
    nb = pen ? 11 : 10;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rx_drv = bits[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); rx_drv = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic drain();
    logic [7:0] d;
    repeat (300) @(negedge clk);
    rd(2'd0, 1'b1, d);
    wr(2'd3, 8'h78);
  endtask

  initial begin
    logic [7:0] d, s;
    int nl, nh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx idle level", tx, 1);
    rd(2'd3, 0, s); chk("R1 status", s, 8'h06);
    rd(2'd1, 0, d); chk("R1 ctrl", d, 0);
    rd(2'd2, 0, d); chk("R1 div", d, 0);

    // R2 bit time at div=2: zero byte = 9 low bits of 48 cycles
    wr(2'd2, 8'd2);
    wr(2'd0, 8'h00);
    wait_level(0); measure(0, nl);
    chk("R2 low span div2", nl, 9 * 16 * 3);
    wait_stat(2, 1);
    wr(2'd2, 8'd0);

    // R3 frame bits: 0x3C with even parity
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h3C);
    wait_level(0);
    repeat (8) @(negedge clk);
    begin
      logic [10:0] exp_bits;
      exp_bits = {1'b1, ^8'h3C, 8'h3C, 1'b0};
      for (int i = 0; i < 11; i++) begin
        chk($sformatf("R3 bit %0d", i), tx, exp_bits[i]);
        repeat (16) @(negedge clk);
      end
    end
    wait_stat(2, 1);

    // R5 R6 R4 break, delimiter, queued data
    for (int b = 0; b < 4; b++) begin
      for (int dl = 0; dl < 4; dl++) begin
        wr(2'd1, 8'(8'h84 | (dl << 5) | (b << 3)));
        fork
          begin wait_level(0); measure(0, nl); measure(1, nh); end
          wr(2'd0, 8'h55);
        join
        chk($sformatf("R5 break sel%0d", b), nl, (13 + b) * 16);
        chk($sformatf("R6 R4 delim sel%0d", dl), nh, (1 + dl) * 16);
        wait_stat(2, 1);
      end
    end

    // R7 break request ignored in slave role
    wr(2'd1, 8'h80);
    rd(2'd3, 0, s); chk("R7 busy bit", s[7], 0);
    nl = 0;
    repeat (400) begin @(negedge clk); if (tx !== 1'b1) nl++; end
    chk("R7 line stays high", nl, 0);

    // R8 loopback sweep, parity sense alternates with value
    drain();
    loop = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(8'h01 | ((v & 1) << 1)));
      wr(2'd0, 8'(v));
      wait_stat(0, 1);
      rd(2'd0, 1'b1, d);
      chk("R8 loopback byte", d, v);
    end
    wait_stat(2, 1);
    rd(2'd3, 0, s); chk("R8 no errors", s[6:3], 0);
    loop = 1'b0;
    drain();

    // R9 parity
    wr(2'd1, 8'h01);
    send_rx(8'h5A, 1, 1, 1);
    rd(2'd3, 0, s); chk("R9 even parity mismatch", s[3], 1);
    rd(2'd0, 1, d); chk("R9 byte delivered", d, 8'h5A);
    wr(2'd3, 8'h78);
    send_rx(8'h5A, 1, 0, 1);
    rd(2'd3, 0, s); chk("R9 even parity good", s[3], 0);
    rd(2'd0, 1, d);
    wr(2'd1, 8'h03);
    send_rx(8'h5A, 1, 1, 1);
    rd(2'd3, 0, s); chk("R9 odd parity good", s[3], 0);
    rd(2'd0, 1, d);

    // R10 framing
    wr(2'd1, 8'h00);
    send_rx(8'h81, 0, 0, 0);
    rd(2'd3, 0, s); chk("R10 frame error", s[4], 1);
    rd(2'd0, 1, d); chk("R10 byte delivered", d, 8'h81);
    rd(2'd3, 0, s); chk("R13 pop clears full", s[0], 0);
    wr(2'd3, 8'h78);
    rd(2'd3, 0, s); chk("R13 w1c clears errors", s[6:3], 0);

    // R11 overrun
    send_rx(8'h11, 0, 0, 1);
    send_rx(8'h22, 0, 0, 1);
    rd(2'd3, 0, s); chk("R11 overrun flag", s[5], 1);
    rd(2'd0, 1, d); chk("R11 first byte kept", d, 8'h11);
    drain();

    // R12 break detection
    @(negedge clk); rx_drv = 1'b0; repeat (160) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd(2'd3, 0, s); chk("R12 10-bit low no detect", s[6], 0);
    drain();
    @(negedge clk); rx_drv = 1'b0; repeat (192) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd(2'd3, 0, s); chk("R12 12-bit low detect", s[6], 1);
    drain();
    rd(2'd3, 0, s); chk("R13 break flag cleared", s[6], 0);
    wr(2'd1, 8'h04);
    @(negedge clk); rx_drv = 1'b0; repeat (192) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd(2'd3, 0, s); chk("R12 master no detect", s[6], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule